// File: doc/BRIEF.md
# Software Flow Controller for a Serial Channel

This block handles in-band flow control for one asynchronous serial channel. It sits between the receive deserializer and the receive FIFO. It watches each incoming character for programmed resume and stop codes, and removes those codes from the data path. It holds back new transmit characters while the remote side has asked for a pause.

The block also looks after the local side of the link. It watches the fill level of the local receive FIFO and injects stop or resume codes into the transmit stream when that level crosses a programmable pair of thresholds. Four code registers hold the codes: resume first, resume second, stop first and stop second. Matching uses either one character or a pair of consecutive characters. A separate detect mode stores every character and pulses a flag when a character equals the second stop code.

The transmitter presents `tx_ready` when it can take a character. The block then chooses between a pending injected code and the head of the transmit queue.

Top module: `xonxoff_flow`

## Requirements
- R1: After reset, all four code registers hold zero, the transmitter is not paused, the flow flag is clear and `fifo_wr` is low. This means a received 0x00 matches in single mode. The stop code wins when a character equals both the stop code and the resume code.
- R2: A write with `cfg_we` high loads `cfg_wdata` into the code register selected by `cfg_sel`: 0 selects resume first, 1 resume second, 2 stop first and 3 stop second.
- R3: With `rx_match_mode` = 01 (single), a character equal to the first stop code sets `tx_paused`. A character equal to the first resume code clears it. Neither character is written to the FIFO.
- R4: With `rx_match_mode` = 10 or 11 (double), two consecutive characters equal to the first and second stop codes pause the transmitter. Two consecutive characters equal to the first and second resume codes resume it. Neither character of a completed pair is written.
- R5: In double mode, a character that matches a first code but is followed by a non-completing character is written to the FIFO, followed by the second character, in arrival order. The second character is itself held if it matches a first code.
- R6: Only the low 5, 6, 7 or 8 bits take part in any comparison, for `word_len` = 0, 1, 2 or 3. Bit 0 is the first data bit.
- R7: A queue character is popped (`txq_pop`) and loaded only when `tx_ready` is high and `tx_paused` is low. Pausing therefore takes effect at the next character boundary.
- R8: A stop match sets the flow flag and a resume match clears it. `flow_irq` is the flag gated by `irq_en`.
- R9: When `tx_send_mode` is not zero, `rx_level` reaching the high mark queues a stop code. `rx_level` then falling to the low mark queues a resume code. For `trig_sel` 0, 1, 2 and 3 the high marks are 4, 8, 12 and 14, and the low marks are 1, 4, 8 and 10.
- R10: `tx_send_mode` = 01 sends the first code only and 1x sends the first then the second code. Queued codes take priority over queue data at each `tx_ready`, and they are sent even while paused.
- R11: With `special_en` high, every received character is written and matching for pause/resume is off. `special_hit` pulses for one cycle when the character equals the second stop code under the word-length mask.
- R12: A character that is not dropped or held appears on `fifo_data` with `fifo_wr` high in the cycle after `rx_valid`. `rx_match_mode` = 00 passes every character. Successive `rx_valid` pulses are at least two cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Code register write strobe |
| cfg_sel | input | 2 | Code register select |
| cfg_wdata | input | 8 | Code register write data |
| rx_match_mode | input | 2 | 00 off, 01 single, 1x double matching |
| tx_send_mode | input | 2 | 00 off, 01 single, 1x double code injection |
| word_len | input | 2 | Character length 5 to 8 bits |
| trig_sel | input | 2 | Threshold pair select |
| special_en | input | 1 | Special-character detect mode |
| irq_en | input | 1 | Flow interrupt enable |
| rx_valid | input | 1 | Received character strobe |
| rx_char | input | 8 | Received character |
| fifo_wr | output | 1 | Receive FIFO write |
| fifo_data | output | 8 | Receive FIFO write data |
| rx_level | input | LVLW | Receive FIFO fill count |
| tx_ready | input | 1 | Transmitter can take a character |
| txq_valid | input | 1 | Transmit queue not empty |
| txq_data | input | 8 | Transmit queue head |
| txq_pop | output | 1 | Transmit queue pop |
| tx_load | output | 1 | Character handed to transmitter |
| tx_char | output | 8 | Character handed to transmitter |
| tx_paused | output | 1 | Remote side asked for a pause |
| flow_irq | output | 1 | Gated flow flag |
| special_hit | output | 1 | Special character seen pulse |

## Verification
The bench builds the block with the default `LVLW` of 5, so `rx_level` covers the whole 0 to 16 range of a 16-entry FIFO. Every high and low mark of all four threshold pairs is crossed in both directions, for both single and double injection.

Because characters are only eight bits wide, the bench can cover word length exhaustively. For each of the four word lengths it flips each of the eight bits of the stop code. The expected match follows directly from the bit position.

// File: rtl/xonxoff_flow.sv
module xonxoff_flow #(
  parameter int LVLW = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [1:0]      cfg_sel,
  input  logic [7:0]      cfg_wdata,
  input  logic [1:0]      rx_match_mode,
  input  logic [1:0]      tx_send_mode,
  input  logic [1:0]      word_len,
  input  logic [1:0]      trig_sel,
  input  logic            special_en,
  input  logic            irq_en,
  input  logic            rx_valid,
  input  logic [7:0]      rx_char,
  output logic            fifo_wr,
  output logic [7:0]      fifo_data,
  input  logic [LVLW-1:0] rx_level,
  input  logic            tx_ready,
  input  logic            txq_valid,
  input  logic [7:0]      txq_data,
  output logic            txq_pop,
  output logic            tx_load,
  output logic [7:0]      tx_char,
  output logic            tx_paused,
  output logic            flow_irq,
  output logic            special_hit
);

  logic [3:0][7:0] chr;
  logic [7:0] mask;
  logic flag, remote_off;
  logic hold_v, hold_on, hold_off, pend_v;
  logic [7:0] hold_c, pend_c;
  logic seq_v, seq_off, seq_idx, seq_two;
  logic [LVLW-1:0] hi_mark, lo_mark;

  function automatic logic eqm(input logic [7:0] a, input logic [7:0] b, input logic [7:0] m);
    return ((a ^ b) & m) == 8'h00;
  endfunction

  assign mask = 8'hFF >> (2'd3 - word_len);

  wire m_on1  = eqm(rx_char, chr[0], mask);
  wire m_on2  = eqm(rx_char, chr[1], mask);
  wire m_off1 = eqm(rx_char, chr[2], mask);
  wire m_off2 = eqm(rx_char, chr[3], mask);
  wire match_on = !special_en && (rx_match_mode != 2'd0);

  always_comb begin
    case (trig_sel)
      2'd0:    begin hi_mark = LVLW'(4);  lo_mark = LVLW'(1);  end
      2'd1:    begin hi_mark = LVLW'(8);  lo_mark = LVLW'(4);  end
      2'd2:    begin hi_mark = LVLW'(12); lo_mark = LVLW'(8);  end
      default: begin hi_mark = LVLW'(14); lo_mark = LVLW'(10); end
    endcase
  end

  assign tx_load  = tx_ready && (seq_v || (txq_valid && !tx_paused));
  assign txq_pop  = tx_ready && !seq_v && txq_valid && !tx_paused;
  assign tx_char  = seq_v ? chr[{seq_off, seq_idx}] : txq_data;
  assign flow_irq = flag && irq_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chr <= '0;
    end else if (cfg_we) begin
      chr[cfg_sel] <= cfg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fifo_wr <= 1'b0; fifo_data <= '0; special_hit <= 1'b0;
      tx_paused <= 1'b0; flag <= 1'b0;
      hold_v <= 1'b0; hold_on <= 1'b0; hold_off <= 1'b0; hold_c <= '0;
      pend_v <= 1'b0; pend_c <= '0;
    end else begin
      fifo_wr <= 1'b0;
      special_hit <= 1'b0;
      if (pend_v) begin
        fifo_wr <= 1'b1; fifo_data <= pend_c; pend_v <= 1'b0;
      end
      if (rx_valid) begin
        if (special_en) begin
          fifo_wr <= 1'b1; fifo_data <= rx_char; special_hit <= m_off2;
        end else if (!match_on) begin
          fifo_wr <= 1'b1; fifo_data <= rx_char;
        end else if (!rx_match_mode[1]) begin
          if (m_off1) begin
            tx_paused <= 1'b1; flag <= 1'b1;
          end else if (m_on1) begin
            tx_paused <= 1'b0; flag <= 1'b0;
          end else begin
            fifo_wr <= 1'b1; fifo_data <= rx_char;
          end
        end else if (hold_v && hold_off && m_off2) begin
          tx_paused <= 1'b1; flag <= 1'b1; hold_v <= 1'b0;
        end else if (hold_v && hold_on && m_on2) begin
          tx_paused <= 1'b0; flag <= 1'b0; hold_v <= 1'b0;
        end else begin
          if (hold_v) begin
            fifo_wr <= 1'b1; fifo_data <= hold_c;
          end
          if (m_off1 || m_on1) begin
            hold_v <= 1'b1; hold_c <= rx_char; hold_on <= m_on1; hold_off <= m_off1;
          end else if (hold_v) begin
            hold_v <= 1'b0; pend_v <= 1'b1; pend_c <= rx_char;
          end else begin
            fifo_wr <= 1'b1; fifo_data <= rx_char;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_v <= 1'b0; seq_off <= 1'b0; seq_idx <= 1'b0; seq_two <= 1'b0; remote_off <= 1'b0;
    end else if (tx_load && seq_v) begin
      if (seq_two && !seq_idx) seq_idx <= 1'b1;
      else seq_v <= 1'b0;
    end else if (!seq_v && tx_send_mode != 2'd0) begin
      if (!remote_off && rx_level >= hi_mark) begin
        seq_v <= 1'b1; seq_off <= 1'b1; seq_idx <= 1'b0;
        seq_two <= tx_send_mode[1]; remote_off <= 1'b1;
      end else if (remote_off && rx_level <= lo_mark) begin
        seq_v <= 1'b1; seq_off <= 1'b0; seq_idx <= 1'b0;
        seq_two <= tx_send_mode[1]; remote_off <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/xonxoff_flow_chk.sv
module xonxoff_flow_chk (
  input logic            clk,
  input logic            rst_n,
  input logic [3:0][7:0] codes,
  input logic [1:0]      rx_match_mode,
  input logic [1:0]      word_len,
  input logic            special_en,
  input logic            irq_en,
  input logic            rx_valid,
  input logic [7:0]      rx_char,
  input logic            fifo_wr,
  input logic [7:0]      fifo_data,
  input logic            tx_ready,
  input logic            txq_valid,
  input logic [7:0]      txq_data,
  input logic            txq_pop,
  input logic            tx_load,
  input logic [7:0]      tx_char,
  input logic            tx_paused,
  input logic            flow_irq
);
  logic [7:0] m;
  assign m = 8'hFF >> (2'd3 - word_len);

  a_r3_stop_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !special_en && rx_match_mode == 2'd1 && ((rx_char ^ codes[2]) & m) == 8'h00)
    |=> (tx_paused && !fifo_wr));

  a_r7_pop_gated: assert property (@(posedge clk) disable iff (!rst_n)
    txq_pop |-> (tx_ready && !tx_paused && tx_load && tx_char == txq_data));

  a_r8_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    flow_irq |-> irq_en);

  a_r10_load_when_free: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ready && txq_valid && !tx_paused) |-> tx_load);

  a_r11_special_stores: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && special_en) |=> (fifo_wr && fifo_data == $past(rx_char) && tx_paused == $past(tx_paused)));

  a_r12_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !special_en && rx_match_mode == 2'd0) |=> (fifo_wr && fifo_data == $past(rx_char)));
endmodule

bind xonxoff_flow xonxoff_flow_chk u_chk (
  .clk(clk), .rst_n(rst_n), .codes(chr), .rx_match_mode(rx_match_mode),
  .word_len(word_len), .special_en(special_en), .irq_en(irq_en),
  .rx_valid(rx_valid), .rx_char(rx_char), .fifo_wr(fifo_wr), .fifo_data(fifo_data),
  .tx_ready(tx_ready), .txq_valid(txq_valid), .txq_data(txq_data), .txq_pop(txq_pop),
  .tx_load(tx_load), .tx_char(tx_char), .tx_paused(tx_paused), .flow_irq(flow_irq)
);

// File: tb/tb_xonxoff_flow.sv
`timescale 1ns/1ps
module tb_xonxoff_flow;
  localparam int LVLW = 5;
  localparam logic [7:0] ON1 = 8'h0C, ON2 = 8'h0A, OFF1 = 8'h13, OFF2 = 8'h14;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0; logic [1:0] cfg_sel = 0; logic [7:0] cfg_wdata = 0;
  logic [1:0] rx_match_mode = 0, tx_send_mode = 0, word_len = 3, trig_sel = 0;
  logic special_en = 0, irq_en = 0, rx_valid = 0;
  logic [7:0] rx_char = 0;
  logic fifo_wr; logic [7:0] fifo_data;
  logic [LVLW-1:0] rx_level = 0;
  logic tx_ready = 0, txq_valid = 0; logic [7:0] txq_data = 8'h77;
  logic txq_pop, tx_load, tx_paused, flow_irq, special_hit;
  logic [7:0] tx_char;

  int tests = 0, fails = 0;
  int rxn = 0, txn = 0, spc = 0;
  logic [7:0] rxlog [64];
  logic [7:0] txlog [64];

  always #10 clk = ~clk;

  xonxoff_flow #(.LVLW(LVLW)) dut (.*);

  always @(negedge clk) begin
    if (fifo_wr) begin if (rxn < 64) rxlog[rxn] = fifo_data; rxn++; end
    if (tx_load) begin if (txn < 64) txlog[txn] = tx_char; txn++; end
    if (special_hit) spc++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin fails++; $display("FAIL %s actual=%0h expected=%0h", req, act, exp); end
  endtask

  task automatic cfg(input logic [1:0] s, input logic [7:0] v);
    @(negedge clk); cfg_we = 1; cfg_sel = s; cfg_wdata = v;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic rxsend(input logic [7:0] c);
    @(negedge clk); rx_char = c; rx_valid = 1;
    @(negedge clk); rx_valid = 0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!tx_paused && !flow_irq && !fifo_wr, "R1 reset state", {tx_paused, flow_irq, fifo_wr}, 0);
    tx_ready = 1; txq_valid = 1;
    #1;
    chk(txq_pop && tx_load && tx_char == 8'h77, "R7 pop when free", {txq_pop, tx_load}, 3);
    txq_valid = 0;

    rx_match_mode = 1; irq_en = 1; rxn = 0;
    rxsend(8'h00);
    chk(rxn == 0 && tx_paused, "R1 zero codes match 00", rxn, 0);

    cfg(0, ON1); cfg(1, ON2); cfg(2, OFF1); cfg(3, OFF2);
    rxsend(ON1);
    chk(!tx_paused && !flow_irq, "R2 resume code loaded", tx_paused, 0);
    rxn = 0;
    rxsend(8'h41);
    chk(rxn == 1 && rxlog[0] == 8'h41, "R12 plain char written", rxlog[0], 8'h41);

    rxsend(OFF1);
    chk(tx_paused && flow_irq, "R3 stop pauses, R8 irq", {tx_paused, flow_irq}, 3);
    irq_en = 0; #1;
    chk(!flow_irq, "R8 irq gated", flow_irq, 0);
    irq_en = 1; #1;
    chk(flow_irq, "R8 flag held", flow_irq, 1);
    rxsend(ON1);
    chk(!tx_paused && !flow_irq && rxn == 1, "R3 resume clears, dropped", rxn, 1);

    for (int wl = 0; wl < 4; wl++) begin
      word_len = 2'(wl);
      for (int b = 0; b < 8; b++) begin
        logic [7:0] c;
        bit expm;
        c = OFF1 ^ (8'h01 << b);
        expm = (b >= 5 + wl);
        rxn = 0;
        rxsend(c);
        if (expm) begin
          chk(rxn == 0 && tx_paused, "R6 masked bit ignored", rxn, 0);
          rxsend(ON1);
        end else begin
          chk(rxn == 1 && rxlog[0] == c && !tx_paused, "R6 compared bit", rxn, 1);
        end
      end
    end
    word_len = 3;

    rx_match_mode = 2; rxn = 0;
    rxsend(OFF1); rxsend(OFF2);
    chk(tx_paused && rxn == 0, "R4 stop pair", rxn, 0);
    rxsend(ON1); rxsend(ON2);
    chk(!tx_paused && rxn == 0, "R4 resume pair", rxn, 0);
    rxsend(OFF1); rxsend(8'h41);
    chk(rxn == 2 && rxlog[0] == OFF1 && rxlog[1] == 8'h41 && !tx_paused, "R5 broken pair order", rxlog[0], OFF1);
    rxn = 0;
    rxsend(OFF1); rxsend(OFF2);
    rxsend(ON1); rxsend(ON1); rxsend(ON2);
    chk(rxn == 1 && rxlog[0] == ON1 && !tx_paused, "R5 rehold first code", rxn, 1);

    special_en = 1; rxn = 0; spc = 0;
    rxsend(OFF2);
    chk(rxn == 1 && rxlog[0] == OFF2 && spc == 1, "R11 special hit stored", spc, 1);
    rxsend(OFF1); rxsend(OFF2);
    chk(rxn == 3 && !tx_paused && spc == 2, "R11 flow off in special", rxn, 3);
    special_en = 0;

    rx_match_mode = 0; rxn = 0;
    rxsend(OFF1);
    chk(rxn == 1 && rxlog[0] == OFF1 && !tx_paused, "R12 mode off passes", rxn, 1);

    for (int tm = 1; tm <= 2; tm++) begin
      for (int ts = 0; ts < 4; ts++) begin
        int hi, lo, n;
        hi = (ts == 3) ? 14 : 4 * (ts + 1);
        lo = (ts == 0) ? 1 : (ts == 3) ? 10 : 4 * ts;
        n = tm;
        tx_send_mode = 2'(tm); trig_sel = 2'(ts); txn = 0;
        for (int l = 0; l <= 16; l++) begin
          @(negedge clk); rx_level = LVLW'(l);
          repeat (3) @(negedge clk);
          if (l == hi - 1) chk(txn == 0, "R9 below high mark", txn, 0);
        end
        chk(txn == n && txlog[0] == OFF1 && (n == 1 || txlog[1] == OFF2), "R9 R10 stop injected", txn, n);
        for (int l = 16; l >= 0; l--) begin
          @(negedge clk); rx_level = LVLW'(l);
          repeat (3) @(negedge clk);
          if (l == lo + 1) chk(txn == n, "R9 above low mark", txn, n);
        end
        chk(txn == 2 * n && txlog[n] == ON1 && (n == 1 || txlog[n+1] == ON2), "R9 R10 resume injected", txn, 2 * n);
      end
    end

    rx_match_mode = 1; tx_send_mode = 2; trig_sel = 3;
    rxsend(OFF1);
    txq_valid = 1;
    @(negedge clk);
    chk(!tx_load && !txq_pop, "R7 paused holds queue", {tx_load, txq_pop}, 0);
    rx_level = 16;
    @(negedge clk);
    chk(tx_load && tx_char == OFF1 && !txq_pop, "R10 inject while paused", tx_char, OFF1);
    @(negedge clk);
    chk(tx_load && tx_char == OFF2 && !txq_pop, "R10 second code", tx_char, OFF2);
    @(negedge clk);
    chk(!tx_load, "R7 paused after inject", tx_load, 0);
    rxsend(ON1);
    chk(txq_pop && tx_char == 8'h77, "R7 queue resumes", txq_pop, 1);
    rx_level = 0;
    @(negedge clk);
    chk(tx_char == ON1 && !txq_pop, "R10 priority over queue", tx_char, ON1);
    @(negedge clk);
    chk(tx_char == ON2 && !txq_pop, "R10 priority second", tx_char, ON2);
    @(negedge clk);
    chk(tx_char == 8'h77 && txq_pop, "R10 queue after codes", tx_char, 8'h77);
    txq_valid = 0;

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule